// File: doc/BRIEF.md
# Two-Wire Serial Shift Interface

This block is a bare-bones shift engine for a two-wire (I2C-style) bus. A processor drives it through a small register port. The hardware does only the bit-level work: it spots start and stop conditions, shifts SDA into a serial register on each rising SCL edge, and drives SDA open-drain from the register's top bit. It also stretches the clock by pulling SCL low. The processor handles all protocol decisions: address matching, acknowledge and transfer direction.

Clock stretching has two causes. The first is a start hold, armed on the first falling SCL edge after a start condition. The second is a 4-bit edge counter that counts both SCL edges and can be preloaded. Starting the counter at 0 frames a full byte, which is 16 edges. Starting it at 14 frames a single acknowledge bit, which is 2 edges. Either way, the processor gets control back with SCL held low.

The register port has three addresses. Address 0 is the shift register. Address 1 is status: bit 7 is the start flag, bit 6 is the overflow flag, bit 5 is the stop flag, and bits 3:0 are the counter. Address 2 is control: bit 0 is the SDA output enable, bit 1 is the start interrupt enable, and bit 2 is the overflow interrupt enable. Bus inputs pass through two-flop synchronizers before any edge detection, so every bus event reaches the flags a few system clocks later.

Top module: `tws_shift_if`

## Requirements
- R1: After reset, the status reads 0x00 and the control reads 0x00, and irq, sclDriveLow and sdaDriveLow are all 0.
- R2: A falling SDA while SCL is high sets status bit 7 (start). A rising SDA while SCL is high sets status bit 5 (stop), and a stop never asserts sclDriveLow.
- R3: Once the start flag is set, the next falling SCL edge asserts sclDriveLow. The signal stays asserted until the start flag is cleared.
- R4: A write to status address 1 clears each of bits 7, 6 and 5 that is written as 1, and loads wrData[3:0] into the counter in the same write.
- R5: Each rising SCL edge shifts the synchronized SDA into bit 0 of the shift register, so a byte sent MSB first reads back unchanged at address 0.
- R6: The counter advances by one on every SCL edge, rising or falling, and is visible in status bits 3:0.
- R7: An SCL edge that finds the counter at 15 wraps the counter to 0, sets status bit 6 (overflow) and asserts sclDriveLow.
- R8: A counter preloaded with 14 overflows after exactly two more SCL edges (one bit), and not after one.
- R9: sdaDriveLow is 1 only when control bit 0 is 1 and bit 7 of the shift register is 0.
- R10: irq is 1 when (start flag and control bit 1) or (overflow flag and control bit 2).
- R11: While both the start hold and the overflow flag are active, clearing only one of them keeps sclDriveLow asserted. It releases only when both are cleared.
- R12: SDA changes while SCL is low set neither the start flag nor the stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 data, 1 status, 2 control) |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data for rdAddr |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit shift register, a 4-bit edge counter and two synchronizer stages. With these values a complete 16-edge byte frame and the preload-to-14 acknowledge frame both fit in a few hundred clocks. The status layout also stays at fixed bit positions that the bench can compare directly. The bench models the bus as wired-AND, so the design's own stretching suppresses edges exactly as it would on a real line. This exercises the case where a start hold and an overflow hold are active together.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef struct packed {
    logic shiftEn;
    logic cntEn;
    logic loadData;
    logic loadCnt;
  } tws_strobe_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic ff [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ff[i] <= 1'b1;
        else       ff[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ff[i] <= 1'b1;
        else       ff[i] <= ff[i-1];
    end
  end

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tws_strobe_t       strb,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] shReg,
  output logic [CNT_W-1:0]  cnt,
  output logic              cntMax
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shReg <= '0;
    else if (strb.loadData) shReg <= wrData;
    else if (strb.shiftEn)  shReg <= {shReg[DATA_W-2:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.loadCnt) cnt <= wrData[CNT_W-1:0];
    else if (strb.cntEn)   cnt <= cnt + 1'b1;
  end

  assign cntMax = &cnt;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [2:0]  wrFlags,
  input  logic [2:0]  wrCfg,
  input  logic        cntMax,
  output tws_strobe_t strb,
  output logic        sdaBit,
  output logic        startFlag,
  output logic        ovfFlag,
  output logic        stopFlag,
  output logic        outEn,
  output logic        startIe,
  output logic        ovfIe,
  output logic        sclDriveLow,
  output logic        irq
);
  logic sclS, sdaS, sclP, sdaP, startHold;
  logic sclRise, sclFall, startEv, stopEv;
  logic statWr, cfgWr, clrStart, clrOvf, clrStop, setOvf;

  tws_sync #(.STAGES(SYNC_STAGES)) i_sclSync (.clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  tws_sync #(.STAGES(SYNC_STAGES)) i_sdaSync (.clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startEv  = sclS & sclP & sdaP & ~sdaS;
  assign stopEv   = sclS & sclP & ~sdaP & sdaS;
  assign statWr   = wrEn && (wrAddr == ADDR_STAT);
  assign cfgWr    = wrEn && (wrAddr == ADDR_CTRL);
  assign clrStart = statWr & wrFlags[2];
  assign clrOvf   = statWr & wrFlags[1];
  assign clrStop  = statWr & wrFlags[0];
  assign setOvf   = sclRise | sclFall ? (cntMax & ~statWr) : 1'b0;

  always_comb begin
    strb.shiftEn  = sclRise;
    strb.cntEn    = sclRise | sclFall;
    strb.loadData = wrEn && (wrAddr == ADDR_DATA);
    strb.loadCnt  = statWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      stopFlag  <= 1'b0;
      startHold <= 1'b0;
    end else begin
      startFlag <= startEv | (startFlag & ~clrStart);
      ovfFlag   <= setOvf  | (ovfFlag & ~clrOvf);
      stopFlag  <= stopEv  | (stopFlag & ~clrStop);
      startHold <= clrStart ? 1'b0 : (startHold | (sclFall & startFlag));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      {ovfIe, startIe, outEn} <= 3'b000;
    else if (cfgWr) {ovfIe, startIe, outEn} <= wrCfg;
  end

  assign sdaBit      = sdaS;
  assign sclDriveLow = startHold | ovfFlag;
  assign irq         = (startFlag & startIe) | (ovfFlag & ovfIe);
endmodule

// File: rtl/tws_shift_if.sv
module tws_shift_if
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int PAD_W = DATA_W - 3 - CNT_W;

  tws_strobe_t       strb;
  logic              sdaBit, cntMax;
  logic              startFlag, ovfFlag, stopFlag, outEn, startIe, ovfIe;
  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  cnt;

  tws_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .wrEn(wrEn), .wrAddr(wrAddr),
    .wrFlags(wrData[DATA_W-1:DATA_W-3]), .wrCfg(wrData[2:0]),
    .cntMax(cntMax), .strb(strb), .sdaBit(sdaBit),
    .startFlag(startFlag), .ovfFlag(ovfFlag), .stopFlag(stopFlag),
    .outEn(outEn), .startIe(startIe), .ovfIe(ovfIe),
    .sclDriveLow(sclDriveLow), .irq(irq)
  );

  tws_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .wrData(wrData), .shReg(shReg), .cnt(cnt), .cntMax(cntMax)
  );

  assign sdaDriveLow = outEn & ~shReg[DATA_W-1];

  always_comb begin
    unique case (rdAddr)
      ADDR_DATA: rdData = shReg;
      ADDR_STAT: rdData = {startFlag, ovfFlag, stopFlag, {PAD_W{1'b0}}, cnt};
      ADDR_CTRL: rdData = {{(DATA_W-3){1'b0}}, ovfIe, startIe, outEn};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclDriveLow,
  input logic             sdaDriveLow,
  input logic             irq,
  input logic             startFlag,
  input logic             ovfFlag,
  input logic             outEn,
  input logic [CNT_W-1:0] cnt,
  input tws_strobe_t      strb
);
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> (startFlag || ovfFlag)); // R11

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (cnt == '0)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntEn && !strb.loadCnt) |=> $stable(cnt)); // R6

  AST_SDA_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> outEn); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (startFlag || ovfFlag)); // R10
endmodule

bind tws_shift_if tws_checker #(.CNT_W(CNT_W)) i_tws_checker (
  .clk(clk), .rstN(rstN), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .irq(irq), .startFlag(startFlag), .ovfFlag(ovfFlag), .outEn(outEn),
  .cnt(cnt), .strb(strb)
);

// File: tb/test_tws_shift_if.sv
module test_tws_shift_if;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       sclDriveLow, sdaDriveLow, irq;
  logic       sclIn, sdaIn;
  int         nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  assign sclIn = sclM & ~sclDriveLow;
  assign sdaIn = sdaM & ~sdaDriveLow;

  tws_shift_if i_tws_shift_if (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  // each entry: {byte shifted in, expected status after the frame}
  localparam logic [15:0] VEC [4] = '{16'hA5_40, 16'h00_40, 16'hFF_40, 16'h3C_40};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busSet(input logic scl, input logic sda);
    @(negedge clk);
    sclM = scl;
    sdaM = sda;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic regRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    regRd(2'd1, v); chk("R1 status", v, 8'h00);
    regRd(2'd2, v); chk("R1 control", v, 8'h00);
    chk("R1 outputs", {5'd0, irq, sclDriveLow, sdaDriveLow}, 8'h00);

    // R2 / R10 start detection with interrupt
    regWr(2'd2, 8'h02);
    busSet(1'b1, 1'b0);
    regRd(2'd1, v); chk("R2 start flag", v, 8'h80);
    chk("R10 start irq", {7'd0, irq}, 8'h01);

    // R3 / R6 hold on next falling edge
    busSet(1'b0, 1'b0);
    chk("R3 hold asserted", {7'd0, sclDriveLow}, 8'h01);
    regRd(2'd1, v); chk("R6 one edge counted", v, 8'h81);
    busSet(1'b0, 1'b1);
    busSet(1'b0, 1'b0);
    regRd(2'd1, v); chk("R12 sda toggle while scl low", v, 8'h81);
    chk("R3 hold kept", {7'd0, sclDriveLow}, 8'h01);

    // R4 clear start and reset counter
    regWr(2'd1, 8'h80);
    regRd(2'd1, v); chk("R4 start cleared", v, 8'h00);
    chk("R3 hold released", {7'd0, sclDriveLow}, 8'h00);
    chk("R10 irq dropped", {7'd0, irq}, 8'h00);

    // R5 / R6 / R7 byte frames from the vector table
    regWr(2'd2, 8'h04);
    for (int i = 0; i < 4; i++) begin
      for (int b = 7; b >= 0; b--) begin
        busSet(1'b0, VEC[i][8+b]);
        busSet(1'b1, VEC[i][8+b]);
        busSet(1'b0, VEC[i][8+b]);
        if (b == 4) begin
          regRd(2'd1, v); chk("R6 mid-byte count", v, 8'h08);
        end
      end
      regRd(2'd0, v); chk("R5 byte shifted", v, VEC[i][15:8]);
      regRd(2'd1, v); chk("R7 overflow status", v, VEC[i][7:0]);
      chk("R7 overflow hold", {7'd0, sclDriveLow}, 8'h01);
      chk("R10 overflow irq", {7'd0, irq}, 8'h01);
      regWr(2'd1, 8'h40);
      chk("R4 overflow cleared", {6'd0, irq, sclDriveLow}, 8'h00);
    end

    // R8 preload 14 frames one bit
    regWr(2'd1, 8'h4E);
    busSet(1'b0, 1'b1);
    busSet(1'b1, 1'b1);
    regRd(2'd1, v); chk("R8 no overflow after one edge", v, 8'h0F);
    busSet(1'b0, 1'b1);
    regRd(2'd1, v); chk("R8 overflow after two edges", v, 8'h40);
    chk("R8 hold after ack", {7'd0, sclDriveLow}, 8'h01);
    regWr(2'd1, 8'h40);
    regWr(2'd2, 8'h00);

    // R9 SDA drive
    regWr(2'd2, 8'h01);
    regWr(2'd0, 8'h7F);
    chk("R9 drive low when msb 0", {7'd0, sdaDriveLow}, 8'h01);
    regWr(2'd0, 8'h80);
    chk("R9 released when msb 1", {7'd0, sdaDriveLow}, 8'h00);
    regWr(2'd2, 8'h00);
    regWr(2'd0, 8'h00);
    chk("R9 released when disabled", {7'd0, sdaDriveLow}, 8'h00);

    // R11 both hold causes
    busSet(1'b1, 1'b1);
    busSet(1'b1, 1'b0);
    regWr(2'd1, 8'h0F);
    busSet(1'b0, 1'b0);
    regRd(2'd1, v); chk("R11 both flags", v, 8'hC0);
    regWr(2'd1, 8'h40);
    chk("R11 still held by start", {7'd0, sclDriveLow}, 8'h01);
    regWr(2'd1, 8'h80);
    chk("R11 released", {7'd0, sclDriveLow}, 8'h00);

    // R2 stop detection
    busSet(1'b1, 1'b0);
    busSet(1'b1, 1'b1);
    regRd(2'd1, v); chk("R2 stop flag", v, 8'h21);
    chk("R2 stop no stretch", {7'd0, sclDriveLow}, 8'h00);
    regWr(2'd1, 8'h20);
    regRd(2'd1, v); chk("R4 stop cleared", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule